// File: doc/BRIEF.md
# Two-Line Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt sources. It drives two request lines toward a processor: a normal line and a fast line. All sources feed one shared raw level vector. Each request line has its own enable mask. A line is asserted while any enabled source is high. There is no priority, vectoring or edge capture. Each line is a registered OR of its masked levels.

Software reaches the block through a word-addressed register bus with one request per cycle. Each mask has one address that sets the bits written as 1 and another address that clears them. Status addresses show the masked and raw views for each line. A software interrupt latch is merged into source 0, so firmware can raise a request without any hardware input. Read data and the error flag are returned one cycle after the request.

Top module: `dual_intc`

## Requirements
- R1: The raw level vector equals the source inputs, with bit 0 also ORed with the software latch. It reads back at word 1 and at word 9.
- R2: `irq_o` is high one clock edge after the raw levels ANDed with the normal-line mask are nonzero. It is low one edge after that product becomes zero.
- R3: `fiq_o` follows the same rule as R2, using the fast-line mask.
- R4: For the normal-line mask, a write to word 2 sets each bit written as 1 and a write to word 3 clears each bit written as 1. All other bits are kept. Word 2 reads back the mask.
- R5: For the fast-line mask, word 10 sets bits, word 11 clears bits and word 10 reads back the mask.
- R6: Word 0 reads the raw levels ANDed with the normal-line mask. Word 8 reads the raw levels ANDed with the fast-line mask.
- R7: A write to word 4 with data bit 0 at 1 sets the software latch. A write to word 5 with bit 0 at 1 clears it. Writes whose bit 0 is 0 leave it unchanged. The latch holds its value between such writes. A read of word 4 returns raw bit 0 in bit 0, with all other bits 0.
- R8: Reads of words 3, 5 and 11 return zero. Writes to words 0, 1, 8 and 9 change no state.
- R9: An access to any word other than 0–5 and 8–11 drives `rsp_err` high for exactly the following cycle. Such a read returns zero, and such an access changes no state.
- R10: A synchronous reset clears both masks, the software latch, both request lines, `rsp_rdata` and `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NSRC | Level interrupt sources, synchronous to clk |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data, one cycle after a read request, otherwise zero |
| rsp_err | output | 1 | One-cycle flag for an access to an undefined word |
| irq_o | output | 1 | Registered normal request line |
| fiq_o | output | 1 | Registered fast request line |

## Verification
The properties assume several things about the inputs. The source levels are already synchronous to `clk`. The request fields hold known values whenever `req_valid` is high. At most one access is presented per cycle. The stimulus keeps within these limits. It changes sources and request fields only on the falling edge, drops `req_valid` between accesses, and uses only addresses that fit in the six-bit word address. That includes the top word, so the out-of-map error path is exercised.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Word offsets; software depends on these positions.
  localparam logic [31:0] W_NRM_STAT = 32'd0;
  localparam logic [31:0] W_RAW_A    = 32'd1;
  localparam logic [31:0] W_NRM_SET  = 32'd2;
  localparam logic [31:0] W_NRM_CLR  = 32'd3;
  localparam logic [31:0] W_SWI_SET  = 32'd4;
  localparam logic [31:0] W_SWI_CLR  = 32'd5;
  localparam logic [31:0] W_FST_STAT = 32'd8;
  localparam logic [31:0] W_RAW_B    = 32'd9;
  localparam logic [31:0] W_FST_SET  = 32'd10;
  localparam logic [31:0] W_FST_CLR  = 32'd11;

  typedef enum logic [3:0] {
    SEL_NRM_STAT,
    SEL_RAW,
    SEL_NRM_SET,
    SEL_NRM_CLR,
    SEL_SWI_SET,
    SEL_SWI_CLR,
    SEL_FST_STAT,
    SEL_FST_SET,
    SEL_FST_CLR,
    SEL_BAD
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [31:0] w);
    reg_sel_e s;
    case (w)
      W_NRM_STAT:       s = SEL_NRM_STAT;
      W_RAW_A, W_RAW_B: s = SEL_RAW;
      W_NRM_SET:        s = SEL_NRM_SET;
      W_NRM_CLR:        s = SEL_NRM_CLR;
      W_SWI_SET:        s = SEL_SWI_SET;
      W_SWI_CLR:        s = SEL_SWI_CLR;
      W_FST_STAT:       s = SEL_FST_STAT;
      W_FST_SET:        s = SEL_FST_SET;
      W_FST_CLR:        s = SEL_FST_CLR;
      default:          s = SEL_BAD;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/intc_mask_reg.sv
// Enable mask with separate set-bits and clear-bits strobes.
module intc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (set_en) mask_q <= mask_q | bits;
    else if (clr_en) mask_q <= mask_q & ~bits;
  end
endmodule

// File: rtl/intc_swi_latch.sv
// Software interrupt latch, acted on only when data bit 0 is 1.
module intc_swi_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_en,
  input  logic clr_en,
  input  logic bit0,
  output logic swi_q
);
  always_ff @(posedge clk) begin
    if (rst)                  swi_q <= 1'b0;
    else if (set_en && bit0)  swi_q <= 1'b1;
    else if (clr_en && bit0)  swi_q <= 1'b0;
  end
endmodule

// File: rtl/intc_out_reg.sv
// Registered OR-reduction of the masked levels for one request line.
module intc_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] mask,
  output logic         line_q
);
  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= |(raw & mask);
  end
endmodule

// File: rtl/intc_readmux.sv
// Combinational read-data selection, zero-extended to the bus width.
module intc_readmux
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  reg_sel_e        sel,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] nrm_mask,
  input  logic [NSRC-1:0] fst_mask,
  output logic [DW-1:0]   rd
);
  logic [NSRC-1:0] view;

  always_comb begin
    case (sel)
      SEL_NRM_STAT: view = raw & nrm_mask;
      SEL_RAW:      view = raw;
      SEL_NRM_SET:  view = nrm_mask;
      SEL_SWI_SET:  view = {{(NSRC-1){1'b0}}, raw[0]};
      SEL_FST_STAT: view = raw & fst_mask;
      SEL_FST_SET:  view = fst_mask;
      default:      view = '0;
    endcase
    rd = '0;
    rd[NSRC-1:0] = view;
  end
endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int NCH = 2;  // channel 0 = normal line, 1 = fast line

  reg_sel_e        sel;
  logic            wr;
  logic            swi_q;
  logic [NSRC-1:0] raw_lvl;
  logic [NSRC-1:0] irq_mask_w;
  logic [NSRC-1:0] fiq_mask_w;
  logic [NSRC-1:0] mask_arr [NCH];
  logic [NCH-1:0]  set_vec;
  logic [NCH-1:0]  clr_vec;
  logic [NCH-1:0]  line_vec;
  logic [DW-1:0]   rd_mux;
  logic [31:0]     addr_ext;

  always_comb begin
    addr_ext = '0;
    addr_ext[AW-1:0] = req_addr;
  end

  assign sel = decode_word(addr_ext);
  assign wr  = req_valid && req_write;

  assign set_vec[0] = wr && (sel == SEL_NRM_SET);
  assign clr_vec[0] = wr && (sel == SEL_NRM_CLR);
  assign set_vec[1] = wr && (sel == SEL_FST_SET);
  assign clr_vec[1] = wr && (sel == SEL_FST_CLR);

  intc_swi_latch u_swi (
    .clk    (clk),
    .rst    (rst),
    .set_en (wr && (sel == SEL_SWI_SET)),
    .clr_en (wr && (sel == SEL_SWI_CLR)),
    .bit0   (req_wdata[0]),
    .swi_q  (swi_q)
  );

  assign raw_lvl = src_lvl | {{(NSRC-1){1'b0}}, swi_q};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    intc_mask_reg #(.W(NSRC)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .set_en (set_vec[ch]),
      .clr_en (clr_vec[ch]),
      .bits   (req_wdata[NSRC-1:0]),
      .mask_q (mask_arr[ch])
    );
    intc_out_reg #(.W(NSRC)) u_out (
      .clk    (clk),
      .rst    (rst),
      .raw    (raw_lvl),
      .mask   (mask_arr[ch]),
      .line_q (line_vec[ch])
    );
  end

  assign irq_mask_w = mask_arr[0];
  assign fiq_mask_w = mask_arr[1];
  assign irq_o      = line_vec[0];
  assign fiq_o      = line_vec[1];

  intc_readmux #(.NSRC(NSRC), .DW(DW)) u_rd (
    .sel      (sel),
    .raw      (raw_lvl),
    .nrm_mask (irq_mask_w),
    .fst_mask (fiq_mask_w),
    .rd       (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
      rsp_err   <= req_valid && (sel == SEL_BAD);
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic [NSRC-1:0] raw,
  input logic [NSRC-1:0] irq_mask,
  input logic [NSRC-1:0] fiq_mask,
  input logic            swi,
  input logic [DW-1:0]   rsp_rdata,
  input logic            rsp_err,
  input logic            irq_o,
  input logic            fiq_o
);
  logic wr;
  assign wr = req_valid && req_write;

  assert_irq_line_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (|($past(raw & irq_mask)))));

  assert_fiq_line_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fiq_o == (|($past(raw & fiq_mask)))));

  assert_nrm_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(irq_mask));

  assert_fst_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(fiq_mask));

  assert_swi_set_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && req_addr == AW'(4) && req_wdata[0]) |=> swi);

  assert_swi_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && req_addr == AW'(5) && req_wdata[0]) |=> !swi);

  assert_clr_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write &&
     (req_addr == AW'(3) || req_addr == AW'(5) || req_addr == AW'(11)))
    |=> (rsp_rdata == '0));

  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));

  assert_err_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid));

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (irq_mask == '0 && fiq_mask == '0 && !swi && !irq_o && !fiq_o
             && !rsp_err));
endmodule

bind dual_intc intc_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .raw       (raw_lvl),
  .irq_mask  (irq_mask_w),
  .fiq_mask  (fiq_mask_w),
  .swi       (swi_q),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/dual_intc_test.sv
`timescale 1ns/1ps
module dual_intc_test;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_lvl = '0;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic [DW-1:0]   rsp_rdata;
  logic            rsp_err;
  logic            irq_o;
  logic            fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_intc #(.NSRC(NSRC), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] src;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_fiq;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 6'd1,  32'h0,        32'h0000_00F0, 32'h0000_00F0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b1, 6'd2,  32'h0000_0030, 32'h0000_00F0, 32'h0,        1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 6'd2,  32'h0,        32'h0000_00F0, 32'h0000_0030, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 6'd0,  32'h0,        32'h0000_0010, 32'h0000_0010, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 6'd10, 32'h0000_0100, 32'h0000_0010, 32'h0,        1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b0, 6'd8,  32'h0,        32'h0000_0110, 32'h0000_0100, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
    '{1'b0, 6'd9,  32'h0,        32'h0000_0110, 32'h0000_0110, 1'b1, 1'b1, 1'b0, 4'd1},  // R1
    '{1'b1, 6'd3,  32'h0000_0020, 32'h0000_0110, 32'h0,        1'b1, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, 6'd3,  32'h0000_0010, 32'h0000_0110, 32'h0,        1'b0, 1'b1, 1'b0, 4'd2},  // R2
    '{1'b1, 6'd11, 32'hFFFF_FFFF, 32'h0000_0110, 32'h0,        1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b0, 6'd10, 32'h0,        32'h0,         32'h0,         1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 6'd2,  32'h0000_0001, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 6'd4,  32'h0000_0001, 32'h0,        32'h0,         1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 6'd4,  32'h0,        32'h0,         32'h0000_0001, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 6'd1,  32'h0,        32'h8000_0000, 32'h8000_0001, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 6'd4,  32'hFFFF_FFFE, 32'h0,        32'h0,         1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 6'd5,  32'hFFFF_FFFE, 32'h0,        32'h0,         1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 6'd5,  32'h0000_0001, 32'h0000_0001, 32'h0,        1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 6'd4,  32'h0,        32'h0,         32'h0,         1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 6'd3,  32'h0,        32'h0,         32'h0,         1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 6'd5,  32'h0,        32'h0000_0001, 32'h0,         1'b1, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 6'd11, 32'h0,        32'h0,         32'h0,         1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b1, 6'd0,  32'hFFFF_FFFF, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b1, 6'd1,  32'hFFFF_FFFF, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b1, 6'd8,  32'hFFFF_FFFF, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b1, 6'd9,  32'hFFFF_FFFF, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 6'd2,  32'h0,        32'h0,         32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 6'd6,  32'h0,        32'h0000_0001, 32'h0,         1'b1, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b1, 6'd12, 32'hFFFF_FFFF, 32'h0,        32'h0,         1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b1, 6'd63, 32'hFFFF_FFFF, 32'h0,        32'h0,         1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b1, 6'd7,  32'hFFFF_FFFF, 32'h0,        32'h0,         1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b0, 6'd2,  32'h0,        32'h0,         32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b0, 6'd10, 32'h0,        32'h0,         32'h0,         1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b0, 6'd4,  32'h0,        32'h0,         32'h0,         1'b0, 1'b0, 1'b0, 4'd9}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access: read data and error sampled after the first edge; the
  // request lines after a second, idle edge, so they reflect updated state.
  task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d,
                      input logic [31:0] s, output logic [31:0] rd,
                      output logic e, output logic irq, output logic fiq);
    @(negedge clk);
    src_lvl = s; req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #2;
    rd = rsp_rdata; e = rsp_err;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    @(posedge clk); #2;
    irq = irq_o; fiq = fiq_o;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    logic e, irq, fiq;

    // R10: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R10 rdata in reset", rsp_rdata, 32'h0);
    chk("R10 err in reset", {31'b0, rsp_err}, 32'h0);
    chk("R10 irq in reset", {31'b0, irq_o}, 32'h0);
    chk("R10 fiq in reset", {31'b0, fiq_o}, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = TBL[i];
      step(t.wr, t.addr, t.wdata, t.src, rd, e, irq, fiq);
      chk($sformatf("R%0d vec %0d rdata", t.req, i), rd, t.exp_rd);
      chk($sformatf("R%0d vec %0d err", t.req, i), {31'b0, e}, {31'b0, t.exp_err});
      chk($sformatf("R%0d vec %0d irq", t.req, i), {31'b0, irq}, {31'b0, t.exp_irq});
      chk($sformatf("R%0d vec %0d fiq", t.req, i), {31'b0, fiq}, {31'b0, t.exp_fiq});
      if (t.exp_err)  // R9: flag lasts one cycle only
        chk($sformatf("R9 vec %0d err cleared", i), {31'b0, rsp_err}, 32'h0);
    end

    // R2: one-edge latency from a source change (normal mask holds bit 0)
    @(negedge clk); src_lvl = 32'h0;
    @(posedge clk); #2;
    chk("R2 line low with source low", {31'b0, irq_o}, 32'h0);
    @(negedge clk); src_lvl = 32'h1;
    #1;
    chk("R2 line not yet high before edge", {31'b0, irq_o}, 32'h0);
    @(posedge clk); #2;
    chk("R2 line high one edge later", {31'b0, irq_o}, 32'h1);

    // R3: fast line latency on a high source
    step(1'b1, 6'd10, 32'h8000_0000, 32'h8000_0000, rd, e, irq, fiq);
    chk("R3 fast line after enable", {31'b0, fiq}, 32'h1);
    @(negedge clk); src_lvl = 32'h0;
    @(posedge clk); #2;
    chk("R3 fast line drops one edge later", {31'b0, fiq_o}, 32'h0);

    // R10: reset in the middle of operation
    step(1'b1, 6'd4, 32'h1, 32'h0, rd, e, irq, fiq);
    chk("R10 pre-reset irq high", {31'b0, irq}, 32'h1);
    @(negedge clk); rst = 1'b1; src_lvl = 32'hFFFF_FFFF;
    @(posedge clk); #2;
    chk("R10 irq cleared by reset", {31'b0, irq_o}, 32'h0);
    chk("R10 fiq cleared by reset", {31'b0, fiq_o}, 32'h0);
    @(negedge clk); rst = 1'b0; src_lvl = 32'h0;
    step(1'b0, 6'd2, 32'h0, 32'h0, rd, e, irq, fiq);
    chk("R10 normal mask zero after reset", rd, 32'h0);
    step(1'b0, 6'd10, 32'h0, 32'h0, rd, e, irq, fiq);
    chk("R10 fast mask zero after reset", rd, 32'h0);
    step(1'b0, 6'd4, 32'h0, 32'h0, rd, e, irq, fiq);
    chk("R10 software latch zero after reset", rd, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule